// File: doc/BRIEF.md
# Privileged Control Register File

This block is the store for the privileged and hyperprivileged control and status registers of one processor strand. Software-visible machine state (address-space selector, timers and their compare values, trap base addresses, processor and hypervisor state words, interrupt level, window and global-set pointers, memory-context identifiers, eight scratch words and eight interrupt/error queue pointers) sits behind a single port. The port is addressed by a 6-bit register ID. A read returns the addressed value combinationally in the same cycle. A write commits on the next rising clock edge.

Several registers are not plain storage. The trap program counter, trap next-PC, trap state, trap type and hypervisor trap state are stacks, `MAX_TL` entries deep. The current trap level selects the entry. Some registers keep only certain bits of a write. The floating-point status word reads with its two low bits forced on. Two aliases set or clear bits of the soft-interrupt word. A packed view of the state the memory unit needs is driven on a dedicated output and can also be read through the port. A write of the trap level updates a trap-level-zero interrupt request. The error flag marks any access that names no implemented register or that is illegal in the current state. Such an access changes nothing.

Top module: `priv_ctl_regfile`

## Requirements
- R1: After reset every register reads 0, except the hypervisor state word (ID 18), which reads 64'h800, and the strand status word (ID 22), which reads 64'h50000. The trap level is 0 and `tlz_irq` is 0.
- R2: With `acc_en` high, `rd_data` shows the addressed register in the same cycle. When `acc_we` is also high, a write commits at the next rising edge. An access that raises `acc_err` modifies no state and reads as 0. With `acc_en` low, `rd_data` is 0.
- R3: IDs 8, 9, 10, 11 and 19 are banked, each `MAX_TL` entries deep. An access uses entry TL−1, so a value written at one trap level reads back unchanged after the level changes and returns.
- R4: Any access to a banked ID while the trap level is 0 raises `acc_err` and leaves every bank entry unchanged.
- R5: A write to the trap base (ID 12) stores the value with bits 14:0 cleared.
- R6: A write to the processor state word (ID 13) keeps only bits 12, 9:6 and 4:1 (mask 64'h13DE). All other bits read 0.
- R7: A read of the floating-point status word (ID 1) returns the stored value OR 2'b11 in bits 1:0.
- R8: A write to the trap level (ID 14) stores the written value, saturated to `MAX_TL` when larger.
- R9: On every trap-level write, `tlz_irq` becomes 1 from the next cycle only if hypervisor state bit 0 is 1, the new level is 0 and hypervisor state bit 2 is 0. Otherwise it becomes 0. No other access changes `tlz_irq`.
- R10: `mmu_ctx_view`, also readable as ID 29, packs these fields: bit 0 = hypervisor state bit 2; bit 1 = hypervisor state bit 5; bits 3:2 = processor state bits 3:2; bits 5:4 = load/store control (ID 28) bits 3:2; bits 15:8 = partition ID (ID 27) bits 7:0; bits 18:16 = trap level; bits 47:32 = primary context (ID 25) bits 15:0; bits 63:48 = secondary context (ID 26) bits 15:0. All other bits are 0. A write to ID 29 raises `acc_err`.
- R11: A write to ID 32 ORs the data into the soft-interrupt word (ID 4). A write to ID 33 clears the bits that are set in the data. Reads of IDs 32 and 33 raise `acc_err`. A write to either alias reads 0.
- R12: IDs 40–47 (scratch) and 48–55 (queue pointers) are plain read/write registers. IDs 30 and 31 (performance counters), 34–39 and 56–63 raise `acc_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_en | input | 1 | Access valid this cycle |
| acc_we | input | 1 | Access is a write |
| acc_id | input | 6 | Register ID |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read data, combinational |
| acc_err | output | 1 | Current access is unimplemented or illegal |
| tlz_irq | output | 1 | Trap-level-zero interrupt request |
| mmu_ctx_view | output | 64 | Packed context view for the memory unit |

## Verification
The bench builds the block with `MAX_TL` = 3, with eight scratch registers and eight queue pointers. With the stack only three deep, random trap-level writes (values 0–7 and occasionally huge) often hit the saturation at the top and the empty state at level 0. Random banked accesses therefore land on every stack entry, on the top-level clamp and on the level-zero error path. Because the level fits in the three view bits, the full packed view is compared on every cycle.

// File: rtl/priv_ctl_pkg.sv
// Package: shared constants, access classes and per-slot write masks / reset
// values for the privileged control register file.
// Assumes a 64-bit data path and a 6-bit register ID space.
package priv_ctl_pkg;

    localparam int DATA_W = 64;
    localparam int ID_W   = 6;

    // Class of register named by an ID.
    typedef enum logic [2:0] {
        K_PLAIN,
        K_BANK,
        K_LEVEL,
        K_VIEW,
        K_SOFT_SET,
        K_SOFT_CLR,
        K_NONE
    } acc_kind_e;

    localparam int N_BANKS       = 5;
    localparam int BANK_W        = 3;
    localparam int N_FIXED_SLOTS = 23;

    // Slot numbers of plain registers with special handling.
    localparam int SLOT_FPRS    = 1;
    localparam int SLOT_SOFTINT = 4;
    localparam int SLOT_TBA     = 8;
    localparam int SLOT_PSTATE  = 9;
    localparam int SLOT_HPSTATE = 13;
    localparam int SLOT_STRAND  = 16;
    localparam int SLOT_PRICTX  = 19;
    localparam int SLOT_SECCTX  = 20;
    localparam int SLOT_PARTID  = 21;
    localparam int SLOT_LSUCTL  = 22;

    // Register IDs that are not plain slots.
    localparam int ID_LEVEL    = 14;
    localparam int ID_HTSTATE  = 19;
    localparam int ID_VIEW     = 29;
    localparam int ID_SOFT_SET = 32;
    localparam int ID_SOFT_CLR = 33;
    localparam int ID_SCR_BASE = 40;
    localparam int ID_QUE_BASE = 48;

    // Hypervisor state bit positions.
    localparam int HP_TLZ   = 0;
    localparam int HP_HPRIV = 2;
    localparam int HP_RED   = 5;

    localparam logic [DATA_W-1:0] PSTATE_KEEP = 64'h0000_0000_0000_13DE;
    localparam logic [DATA_W-1:0] TBA_KEEP    = ~64'h0000_0000_0000_7FFF;
    localparam logic [DATA_W-1:0] FPRS_FORCE  = 64'h0000_0000_0000_0003;

    // Bits of a write that a plain slot keeps.
    function automatic logic [DATA_W-1:0] slot_keep(input int s);
        if (s == SLOT_TBA)    return TBA_KEEP;
        if (s == SLOT_PSTATE) return PSTATE_KEEP;
        return '1;
    endfunction

    // Reset value of a plain slot.
    function automatic logic [DATA_W-1:0] slot_reset(input int s);
        if (s == SLOT_HPSTATE) return 64'h0000_0000_0000_0800;
        if (s == SLOT_STRAND)  return 64'h0000_0000_0005_0000;
        return '0;
    endfunction

endpackage

// File: rtl/pcr_id_decode.sv
// Module: pcr_id_decode
// Maps a register ID onto an access class, a plain-slot number and a bank
// number. Purely combinational. Assumes N_SCRATCH and N_QUEUE are each at
// most 8 so their ID windows do not overlap.
module pcr_id_decode
    import priv_ctl_pkg::*;
#(
    parameter int N_SCRATCH = 8,
    parameter int N_QUEUE   = 8,
    parameter int SLOT_W    = 6
) (
    input  logic [ID_W-1:0]   id,
    output acc_kind_e         kind,
    output logic [SLOT_W-1:0] slot,
    output logic [BANK_W-1:0] bank
);

    localparam int SCR_SLOT0 = N_FIXED_SLOTS;
    localparam int QUE_SLOT0 = N_FIXED_SLOTS + N_SCRATCH;

    int idv;

    // Classify the ID and compute the slot or bank index it selects.
    always_comb begin
        idv  = int'(id);
        kind = K_NONE;
        slot = '0;
        bank = '0;
        if (idv < 8) begin
            kind = K_PLAIN;
            slot = SLOT_W'(idv);
        end else if (idv <= 11) begin
            kind = K_BANK;
            bank = BANK_W'(idv - 8);
        end else if (idv == ID_HTSTATE) begin
            kind = K_BANK;
            bank = BANK_W'(4);
        end else if (idv == ID_LEVEL) begin
            kind = K_LEVEL;
        end else if (idv == ID_VIEW) begin
            kind = K_VIEW;
        end else if (idv == ID_SOFT_SET) begin
            kind = K_SOFT_SET;
        end else if (idv == ID_SOFT_CLR) begin
            kind = K_SOFT_CLR;
        end else if (idv == 12 || idv == 13) begin
            kind = K_PLAIN;
            slot = SLOT_W'(idv - 4);
        end else if (idv >= 15 && idv <= 18) begin
            kind = K_PLAIN;
            slot = SLOT_W'(idv - 5);
        end else if (idv >= 20 && idv <= 28) begin
            kind = K_PLAIN;
            slot = SLOT_W'(idv - 6);
        end else if (idv >= ID_SCR_BASE && idv < ID_SCR_BASE + N_SCRATCH) begin
            kind = K_PLAIN;
            slot = SLOT_W'(SCR_SLOT0 + idv - ID_SCR_BASE);
        end else if (idv >= ID_QUE_BASE && idv < ID_QUE_BASE + N_QUEUE) begin
            kind = K_PLAIN;
            slot = SLOT_W'(QUE_SLOT0 + idv - ID_QUE_BASE);
        end
    end

endmodule

// File: rtl/pcr_trap_bank.sv
// Module: pcr_trap_bank
// One trap-level-indexed stack of 64-bit entries. Reads are combinational.
// A write lands at the next edge. Assumes the caller only enables a write
// with an in-range index; an out-of-range index reads 0 and writes nothing.
module pcr_trap_bank
    import priv_ctl_pkg::*;
#(
    parameter int DEPTH = 6,
    parameter int IDX_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data
);

    logic [DATA_W-1:0] ent_q [DEPTH];
    logic              idx_ok;

    // Index range guard.
    always_comb idx_ok = int'(idx) < DEPTH;

    // Entry storage: clear on reset, update the indexed entry on a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) ent_q[i] <= '0;
        end else if (wr_en && idx_ok) begin
            ent_q[idx] <= wr_data;
        end
    end

    // Combinational read of the indexed entry.
    always_comb rd_data = idx_ok ? ent_q[idx] : '0;

endmodule

// File: rtl/pcr_ctx_view.sv
// Module: pcr_ctx_view
// Packs the mode bits, trap level and context identifiers into the 64-bit
// view used by the memory unit. Purely combinational.
module pcr_ctx_view
    import priv_ctl_pkg::*;
(
    input  logic              hp_hpriv,
    input  logic              hp_red,
    input  logic [1:0]        ps_mode,
    input  logic [1:0]        lsu_en,
    input  logic [7:0]        part_id,
    input  logic [2:0]        level,
    input  logic [15:0]       pri_ctx,
    input  logic [15:0]       sec_ctx,
    output logic [DATA_W-1:0] view
);

    // Field placement.
    always_comb begin
        view         = '0;
        view[0]      = hp_hpriv;
        view[1]      = hp_red;
        view[3:2]    = ps_mode;
        view[5:4]    = lsu_en;
        view[15:8]   = part_id;
        view[18:16]  = level;
        view[47:32]  = pri_ctx;
        view[63:48]  = sec_ctx;
    end

endmodule

// File: rtl/pcr_tlz_irq.sv
// Module: pcr_tlz_irq
// Holds the trap-level-zero interrupt request. It is re-evaluated only when
// the trap level is written and holds between such writes.
module pcr_tlz_irq (
    input  logic clk,
    input  logic rst_n,
    input  logic level_wr,
    input  logic new_level_zero,
    input  logic hp_tlz,
    input  logic hp_hpriv,
    output logic irq
);

    // Request register: set or clear on each trap-level write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else if (level_wr) begin
            irq <= hp_tlz && new_level_zero && !hp_hpriv;
        end
    end

endmodule

// File: rtl/priv_ctl_regfile.sv
// Module: priv_ctl_regfile (top)
// Privileged / hyperprivileged control register file with a single
// combinational-read, edge-write port addressed by register ID. Applies
// per-register write masks and reset values and banks the trap registers
// by trap level. Drives the trap-level-zero request and the packed context
// view. Assumes MAX_TL <= 7 so the level fits the 3-bit view field.
module priv_ctl_regfile
    import priv_ctl_pkg::*;
#(
    parameter int MAX_TL    = 6,
    parameter int N_SCRATCH = 8,
    parameter int N_QUEUE   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_en,
    input  logic              acc_we,
    input  logic [5:0]        acc_id,
    input  logic [63:0]       wr_data,
    output logic [63:0]       rd_data,
    output logic              acc_err,
    output logic              tlz_irq,
    output logic [63:0]       mmu_ctx_view
);

    localparam int N_SLOTS = N_FIXED_SLOTS + N_SCRATCH + N_QUEUE;
    localparam int SLOT_W  = $clog2(N_SLOTS);
    localparam int TL_W    = $clog2(MAX_TL + 1);
    localparam int IDX_W   = (MAX_TL > 1) ? $clog2(MAX_TL) : 1;

    acc_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic [BANK_W-1:0] bank;
    logic              commit;
    logic [TL_W-1:0]   tl_q;
    logic [TL_W-1:0]   tl_new;
    logic              level_wr;
    logic [IDX_W-1:0]  bank_idx;
    logic [2:0]        tl3;
    logic [DATA_W-1:0] slot_val [N_SLOTS];
    logic [DATA_W-1:0] bank_rd  [N_BANKS];

    pcr_id_decode #(
        .N_SCRATCH (N_SCRATCH),
        .N_QUEUE   (N_QUEUE),
        .SLOT_W    (SLOT_W)
    ) u_decode (
        .id   (acc_id),
        .kind (kind),
        .slot (slot),
        .bank (bank)
    );

    // Error classification for the current access.
    always_comb begin
        acc_err = 1'b0;
        if (acc_en) begin
            unique case (kind)
                K_NONE:                 acc_err = 1'b1;
                K_BANK:                 acc_err = (tl_q == '0);
                K_VIEW:                 acc_err = acc_we;
                K_SOFT_SET, K_SOFT_CLR: acc_err = !acc_we;
                default:                acc_err = 1'b0;
            endcase
        end
    end

    // A write that is legal commits at the next edge.
    always_comb commit = acc_en && acc_we && !acc_err;

    // Plain slots: one register per slot with its own mask and reset value.
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        logic [DATA_W-1:0] val_q;
        logic [DATA_W-1:0] val_nxt;

        // Next value: masked plain write, or soft-interrupt set/clear alias.
        always_comb begin
            val_nxt = val_q;
            if (commit && kind == K_PLAIN && int'(slot) == s) begin
                val_nxt = wr_data & slot_keep(s);
            end
            if (s == SLOT_SOFTINT && commit && kind == K_SOFT_SET) begin
                val_nxt = val_q | wr_data;
            end
            if (s == SLOT_SOFTINT && commit && kind == K_SOFT_CLR) begin
                val_nxt = val_q & ~wr_data;
            end
        end

        // Slot register with its reset constant.
        always_ff @(posedge clk) begin
            if (!rst_n) val_q <= slot_reset(s);
            else        val_q <= val_nxt;
        end

        assign slot_val[s] = val_q;
    end

    // Saturated trap-level write value.
    always_comb begin
        if (wr_data > 64'(MAX_TL)) tl_new = TL_W'(MAX_TL);
        else                       tl_new = TL_W'(wr_data);
        level_wr = commit && kind == K_LEVEL;
    end

    // Trap level register.
    always_ff @(posedge clk) begin
        if (!rst_n)        tl_q <= '0;
        else if (level_wr) tl_q <= tl_new;
    end

    // Bank index is TL-1; only used when TL is non-zero.
    always_comb bank_idx = IDX_W'(tl_q - TL_W'(1));

    // Trap-level-indexed stacks.
    for (genvar k = 0; k < N_BANKS; k++) begin : g_bank
        pcr_trap_bank #(
            .DEPTH (MAX_TL),
            .IDX_W (IDX_W)
        ) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (commit && kind == K_BANK && int'(bank) == k),
            .idx     (bank_idx),
            .wr_data (wr_data),
            .rd_data (bank_rd[k])
        );
    end

    pcr_tlz_irq u_tlz (
        .clk            (clk),
        .rst_n          (rst_n),
        .level_wr       (level_wr),
        .new_level_zero (tl_new == '0),
        .hp_tlz         (slot_val[SLOT_HPSTATE][HP_TLZ]),
        .hp_hpriv       (slot_val[SLOT_HPSTATE][HP_HPRIV]),
        .irq            (tlz_irq)
    );

    // Level widened or narrowed to the 3-bit view field.
    always_comb tl3 = 3'(tl_q);

    pcr_ctx_view u_view (
        .hp_hpriv (slot_val[SLOT_HPSTATE][HP_HPRIV]),
        .hp_red   (slot_val[SLOT_HPSTATE][HP_RED]),
        .ps_mode  (slot_val[SLOT_PSTATE][3:2]),
        .lsu_en   (slot_val[SLOT_LSUCTL][3:2]),
        .part_id  (slot_val[SLOT_PARTID][7:0]),
        .level    (tl3),
        .pri_ctx  (slot_val[SLOT_PRICTX][15:0]),
        .sec_ctx  (slot_val[SLOT_SECCTX][15:0]),
        .view     (mmu_ctx_view)
    );

    // Read multiplexer; errors and idle cycles read 0.
    always_comb begin
        rd_data = '0;
        if (acc_en && !acc_err) begin
            unique case (kind)
                K_PLAIN: begin
                    rd_data = slot_val[slot];
                    if (int'(slot) == SLOT_FPRS) rd_data = rd_data | FPRS_FORCE;
                end
                K_BANK:  rd_data = bank_rd[bank];
                K_LEVEL: rd_data = 64'(tl_q);
                K_VIEW:  rd_data = mmu_ctx_view;
                default: rd_data = '0;
            endcase
        end
    end

endmodule

// File: rtl/priv_ctl_regfile_chk.sv
// Module: priv_ctl_regfile_chk
// Property checker for priv_ctl_regfile, attached by bind. Observes only the
// ports of the top module.
module priv_ctl_regfile_chk #(
    parameter int MAX_TL = 6
) (
    input logic        clk,
    input logic        rst_n,
    input logic        acc_en,
    input logic        acc_we,
    input logic [5:0]  acc_id,
    input logic [63:0] rd_data,
    input logic        acc_err,
    input logic        tlz_irq,
    input logic [2:0]  view_tl
);

    logic rd_ok;
    logic bank_id;

    // Helper terms for the properties.
    always_comb begin
        rd_ok   = acc_en && !acc_we && !acc_err;
        bank_id = (acc_id >= 6'd8 && acc_id <= 6'd11) || acc_id == 6'd19;
    end

    // Failed accesses read zero (R2).
    assert_err_reads_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && acc_err) |-> rd_data == 64'd0);

    // Banked access at level zero is flagged (R4).
    assert_bank_level0_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && bank_id && view_tl == 3'd0) |-> acc_err);

    // Trap base low bits always read zero (R5).
    assert_tba_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && acc_id == 6'd12) |-> rd_data[14:0] == 15'd0);

    // Processor state never shows bits outside its mask (R6).
    assert_pstate_mask_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && acc_id == 6'd13) |-> (rd_data & ~64'h13DE) == 64'd0);

    // Floating-point status reads with low bits set (R7).
    assert_fprs_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_ok && acc_id == 6'd1) |-> rd_data[1:0] == 2'b11);

    // Trap level never exceeds the stack depth (R8).
    assert_level_sat_R8: assert property (@(posedge clk) disable iff (!rst_n)
        int'(view_tl) <= MAX_TL);

    // The interrupt request only moves after a trap-level write (R9).
    assert_irq_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(acc_en && acc_we && acc_id == 6'd14 && !acc_err) |-> $stable(tlz_irq));

    // Performance-counter IDs are unimplemented (R12).
    assert_perf_unimpl_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_en && (acc_id == 6'd30 || acc_id == 6'd31)) |-> acc_err);

endmodule

bind priv_ctl_regfile priv_ctl_regfile_chk #(.MAX_TL(MAX_TL)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .acc_en  (acc_en),
    .acc_we  (acc_we),
    .acc_id  (acc_id),
    .rd_data (rd_data),
    .acc_err (acc_err),
    .tlz_irq (tlz_irq),
    .view_tl (mmu_ctx_view[18:16])
);

// File: tb/test_priv_ctl_regfile.sv
// Bench for priv_ctl_regfile: directed corner cases plus seeded random
// accesses, checked against a bench-side model built from the requirements.
module test_priv_ctl_regfile;

    localparam int MAX_TL = 3;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_en = 1'b0;
    logic        acc_we = 1'b0;
    logic [5:0]  acc_id = '0;
    logic [63:0] wr_data = '0;
    logic [63:0] rd_data;
    logic        acc_err;
    logic        tlz_irq;
    logic [63:0] mmu_ctx_view;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    // Model state.
    logic [63:0] m_reg [64];
    logic [63:0] m_bank [5][MAX_TL];
    int          m_tl;
    logic        m_irq;

    priv_ctl_regfile #(.MAX_TL(MAX_TL), .N_SCRATCH(8), .N_QUEUE(8)) i_priv_ctl_regfile (
        .clk (clk), .rst_n (rst_n), .acc_en (acc_en), .acc_we (acc_we),
        .acc_id (acc_id), .wr_data (wr_data), .rd_data (rd_data),
        .acc_err (acc_err), .tlz_irq (tlz_irq), .mmu_ctx_view (mmu_ctx_view)
    );

    always #5 clk = ~clk;

    function automatic bit is_plain(input int id);
        return (id <= 7) || id == 12 || id == 13 || (id >= 15 && id <= 18) ||
               (id >= 20 && id <= 28) || (id >= 40 && id <= 55);
    endfunction

    function automatic int bank_of(input int id);
        if (id >= 8 && id <= 11) return id - 8;
        if (id == 19) return 4;
        return -1;
    endfunction

    function automatic logic [63:0] keep_of(input int id);
        if (id == 12) return ~64'h7FFF;
        if (id == 13) return 64'h13DE;
        return '1;
    endfunction

    function automatic bit exp_err(input int id, input bit we);
        if (is_plain(id) || id == 14) return 1'b0;
        if (bank_of(id) >= 0) return m_tl == 0;
        if (id == 29) return we;
        if (id == 32 || id == 33) return !we;
        return 1'b1;
    endfunction

    function automatic logic [63:0] exp_view();
        logic [63:0] v = '0;
        v[0]     = m_reg[18][2];
        v[1]     = m_reg[18][5];
        v[3:2]   = m_reg[13][3:2];
        v[5:4]   = m_reg[28][3:2];
        v[15:8]  = m_reg[27][7:0];
        v[18:16] = 3'(m_tl);
        v[47:32] = m_reg[25][15:0];
        v[63:48] = m_reg[26][15:0];
        return v;
    endfunction

    function automatic logic [63:0] exp_rd(input int id, input bit we);
        if (exp_err(id, we)) return '0;
        if (is_plain(id)) return (id == 1) ? (m_reg[id] | 64'h3) : m_reg[id];
        if (bank_of(id) >= 0) return m_bank[bank_of(id)][m_tl-1];
        if (id == 14) return 64'(m_tl);
        if (id == 29) return exp_view();
        return '0;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int i = 0; i < 64; i++) m_reg[i] = '0;
        for (int k = 0; k < 5; k++)
            for (int e = 0; e < MAX_TL; e++) m_bank[k][e] = '0;
        m_reg[18] = 64'h800;
        m_reg[22] = 64'h50000;
        m_tl  = 0;
        m_irq = 1'b0;
    endtask

    // One port access; checks read data and error before the edge, then the
    // interrupt request and packed view after it.
    task automatic access(input string tag, input bit en, input bit we,
                          input int id, input logic [63:0] data);
        bit          e_err;
        logic [63:0] e_rd;
        @(negedge clk);
        acc_en  = en;
        acc_we  = we;
        acc_id  = 6'(id);
        wr_data = data;
        e_err = en && exp_err(id, we);
        e_rd  = en ? exp_rd(id, we) : '0;
        #1;
        check({tag, " rd_data"}, rd_data, e_rd);
        check({tag, " acc_err"}, 64'(acc_err), 64'(e_err));
        @(posedge clk);
        if (en && we && !e_err) begin
            if (is_plain(id)) m_reg[id] = data & keep_of(id);
            else if (bank_of(id) >= 0) m_bank[bank_of(id)][m_tl-1] = data;
            else if (id == 14) begin
                m_tl  = (data > 64'(MAX_TL)) ? MAX_TL : int'(data);
                m_irq = m_reg[18][0] && m_tl == 0 && !m_reg[18][2];
            end else if (id == 32) m_reg[4] = m_reg[4] | data;
            else if (id == 33) m_reg[4] = m_reg[4] & ~data;
        end
        #1;
        check("R9 tlz_irq", 64'(tlz_irq), 64'(m_irq));
        check("R10 mmu_ctx_view", mmu_ctx_view, exp_view());
    endtask

    task automatic rd(input string tag, input int id);
        access(tag, 1'b1, 1'b0, id, '0);
    endtask

    task automatic wr(input string tag, input int id, input logic [63:0] d);
        access(tag, 1'b1, 1'b1, id, d);
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        #2_000_000;
        if (!done) begin
            n_fail++;
            $display("FAIL R2 watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values across the whole ID space.
        for (int id = 0; id < 64; id++) rd("R1 reset scan", id);

        // R2: idle port reads zero; erroneous write changes nothing.
        access("R2 idle", 1'b0, 1'b1, 40, 64'hDEAD);
        rd("R2 idle no write", 40);
        wr("R2 scratch write", 41, 64'h0123_4567_89AB_CDEF);
        rd("R2 scratch read", 41);

        // R4: banked access at level 0 is flagged and changes nothing.
        wr("R4 bank write TL0", 8, 64'hBAD);
        rd("R4 bank read TL0", 19);

        // R3: entries per level.
        wr("R3 level 1", 14, 64'd1);
        rd("R4 entry untouched", 8);
        wr("R3 tpc lvl1", 8, 64'hAAAA_0001);
        wr("R3 htstate lvl1", 19, 64'hCCCC_0001);
        wr("R3 level 2", 14, 64'd2);
        wr("R3 tpc lvl2", 8, 64'hAAAA_0002);
        wr("R3 level 3", 14, 64'd3);
        wr("R3 tpc lvl3", 8, 64'hAAAA_0003);
        wr("R3 back to 1", 14, 64'd1);
        rd("R3 tpc lvl1 read", 8);
        rd("R3 htstate lvl1 read", 19);
        wr("R3 back to 2", 14, 64'd2);
        rd("R3 tpc lvl2 read", 8);

        // R8: saturation at MAX_TL.
        wr("R8 level 9", 14, 64'd9);
        rd("R8 level read", 14);
        rd("R8 top entry", 8);
        wr("R8 huge level", 14, 64'h8000_0000_0000_0001);
        rd("R8 huge read", 14);

        // R5, R6, R7: masks and forced bits.
        wr("R5 tba", 12, '1);
        rd("R5 tba read", 12);
        wr("R6 pstate", 13, '1);
        rd("R6 pstate read", 13);
        wr("R7 fprs", 1, 64'h0);
        rd("R7 fprs read", 1);

        // R9: interrupt request set, cleared, blocked and held.
        wr("R9 hp tlz", 18, 64'h1);
        wr("R9 level0", 14, 64'd0);
        wr("R9 other write", 40, 64'h55);
        wr("R9 hp cleared", 18, 64'h0);
        rd("R9 held", 4);
        wr("R9 level2", 14, 64'd2);
        wr("R9 hp tlz+hpriv", 18, 64'h5);
        wr("R9 level0 hpriv", 14, 64'd0);
        wr("R9 hp tlz again", 18, 64'h1);
        wr("R9 level0 again", 14, 64'd0);

        // R10: packed view fields, read through the port, write flagged.
        wr("R10 hp", 18, 64'h24);
        wr("R10 pstate", 13, 64'hC);
        wr("R10 lsu", 28, 64'hC);
        wr("R10 part", 27, 64'h1AB);
        wr("R10 pri", 25, 64'hF_1234);
        wr("R10 sec", 26, 64'hF_5678);
        wr("R10 level3", 14, 64'd3);
        rd("R10 view read", 29);
        wr("R10 view write", 29, '1);

        // R11: soft-interrupt set/clear aliases.
        wr("R11 soft base", 4, 64'h00F0);
        wr("R11 soft set", 32, 64'h0F01);
        rd("R11 soft after set", 4);
        wr("R11 soft clr", 33, 64'h00F1);
        rd("R11 soft after clr", 4);
        rd("R11 set read", 32);
        rd("R11 clr read", 33);

        // R12: scratch and queue storage; unimplemented IDs.
        for (int id = 40; id < 56; id++) wr("R12 store", id, {32'(id), 32'hA5A5_0000 + 32'(id)});
        for (int id = 40; id < 56; id++) rd("R12 reload", id);
        wr("R12 perf ctl", 30, 64'h1);
        rd("R12 perf cnt", 31);
        rd("R12 hole 36", 36);
        rd("R12 hole 60", 60);

        // R2: seeded random accesses over the whole ID space.
        for (int n = 0; n < 4000; n++) begin
            int          id;
            bit          en;
            bit          we;
            logic [63:0] d;
            id = int'($urandom_range(0, 63));
            if ($urandom_range(0, 3) == 0) id = 8 + int'($urandom_range(0, 6));
            en = $urandom_range(0, 9) != 0;
            we = $urandom_range(0, 1) == 1;
            d  = {$urandom, $urandom};
            if (id == 14 && $urandom_range(0, 7) != 0) d = 64'($urandom_range(0, 7));
            if (id == 18 && $urandom_range(0, 1) == 1) d = 64'($urandom_range(0, 7));
            access("R2 random", en, we, id, d);
        end

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule